// File: doc/BRIEF.md
# Power-of-Two Tick Divider with Off Code

This block turns one reference clock into three independent streams of clock-enable ticks. Each stream has a 3-bit log-encoded code: code 0 switches the stream off, and a nonzero code n makes the stream emit a one-cycle tick once every 2^(n-1) reference cycles. Code 1 therefore ticks on every cycle and code 7 ticks once every 64 cycles. The ticks are enables in the reference domain and are not derived clocks. A consumer qualifies its own flops with them.

The codes are written into one configuration word through a plain write strobe with an address. When software writes a new code, that code waits until the stream's current division period ends, so the stream never produces a shortened interval. A separate status word shows the code each stream is actually running and whether the source is valid. While the source-valid input is low, every stream is held quiet and restarts its count when the source returns.

Top module: `pow2_tick_divider`

## Requirements
- R1: The three streams run side by side from the same reference, each from its own code, and none affects the others' spacing.
- R2: A stream whose running code is 0 produces no ticks.
- R3: A stream running code n (1 to 7) produces a tick one cycle wide exactly every 2^(n-1) cycles. Code 1 ticks on every cycle.
- R4: In any cycle that follows a cycle with `src_valid` low, every bit of `tick_o` is 0.
- R5: While `src_valid` is low, each stream adopts its written code and clears its count. The first tick after `src_valid` returns comes 2^(n-1) cycles after the first valid cycle.
- R6: A written code waits for the stream's next tick, which ends the running period. The interval that ends at that tick keeps the old spacing, and the following intervals use the new code. A stream that is off adopts the code in the cycle after the write, and its first tick comes 2^(n-1) cycles later.
- R7: A write with `addr` = 0 stores the codes of stream 0, 1 and 2 from bits [2:0], [6:4] and [10:8]. A read at address 0 returns those codes at the same positions, with all other bits 0.
- R8: A read at address 1 returns the running codes at the same positions and `src_valid` in bit 12. Writes to any address other than 0 are ignored, and addresses 2 and 3 read as 0.
- R9: A synchronous reset (`rst` high at a clock edge) clears all stored and running codes and drives `tick_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Reference is stable and usable |
| wr_en | input | 1 | Write strobe for the configuration word |
| addr | input | 2 | Register address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational readback of the addressed word |
| tick_o | output | 3 | One-cycle enable ticks, one per stream |

## Verification
A write at a clock edge shows in the address-0 readback immediately after that edge. The running code of a stream changes at the edge that follows its period boundary. Every tick is registered, so a tick reflects the counter and `src_valid` from the previous cycle. The bench keeps a countdown model that it advances at each rising edge from the inputs held across that edge, and it compares `tick_o` and `rd_data` with the model at the falling edge of every cycle. The directed checks count the cycle distance between ticks against the cycle counter, and they measure from the cycle in which a write or a return of `src_valid` is seen at an edge.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;

    // width of one stream's log-encoded divide code
    localparam int CODE_W = 3;
    // counter width: largest period is 2^(2^CODE_W - 2)
    localparam int CNT_W  = (1 << CODE_W) - 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  count_t;

    // per-stream registered state
    typedef struct packed {
        code_t  act;   // code currently running
        count_t cnt;   // position inside the running period
        logic   tick;  // registered enable output
    } chan_state_t;

endpackage

// File: rtl/pow2_div_chan.sv
module pow2_div_chan
    import pow2_div_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  src_valid,
    input  code_t pend_code,
    output code_t act_code,
    output logic  tick
);

    chan_state_t st_d, st_q;

    logic [CNT_W:0] span;
    logic [CNT_W:0] span_m1;
    count_t         last_cnt;
    logic           at_end;

    // period length for the running code, minus one
    always_comb begin
        span     = {{CNT_W{1'b0}}, 1'b1} << (st_q.act - code_t'(1));
        span_m1  = span - {{CNT_W{1'b0}}, 1'b1};
        last_cnt = span_m1[CNT_W-1:0];
        at_end   = (st_q.act != '0) && (st_q.cnt == last_cnt);
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = src_valid && at_end;
        if (!src_valid) begin
            // quiet source: adopt the new code now, restart the count
            st_d.act = pend_code;
            st_d.cnt = '0;
        end else if ((st_q.act == '0) || at_end) begin
            // period boundary: the only place a code may change
            st_d.act = pend_code;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_code = st_q.act;
    assign tick     = st_q.tick;

endmodule

// File: rtl/pow2_cfg_regs.sv
module pow2_cfg_regs
    import pow2_div_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int STRIDE = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     src_valid,
    input  logic [NUM_CH*CODE_W-1:0] act_codes,
    output logic [NUM_CH*CODE_W-1:0] pend_codes,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int          VALID_BIT = NUM_CH * STRIDE;
    localparam [ADDR_W-1:0] A_CFG     = ADDR_W'(0);
    localparam [ADDR_W-1:0] A_STAT    = ADDR_W'(1);

    logic [NUM_CH*CODE_W-1:0] pend_d, pend_q;
    logic [DATA_W-1:0]        cfg_word;
    logic [DATA_W-1:0]        stat_word;

    // next stored codes: fields lifted out of the write word
    always_comb begin
        pend_d = pend_q;
        if (wr_en && (addr == A_CFG)) begin
            for (int i = 0; i < NUM_CH; i++) begin
                pend_d[i*CODE_W +: CODE_W] = wr_data[i*STRIDE +: CODE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    // readback words, fields spread over the same positions
    always_comb begin
        cfg_word  = '0;
        stat_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            cfg_word[i*STRIDE +: CODE_W]  = pend_q[i*CODE_W +: CODE_W];
            stat_word[i*STRIDE +: CODE_W] = act_codes[i*CODE_W +: CODE_W];
        end
        stat_word[VALID_BIT] = src_valid;
    end

    always_comb begin
        case (addr)
            A_CFG:   rd_data = cfg_word;
            A_STAT:  rd_data = stat_word;
            default: rd_data = '0;
        endcase
    end

    assign pend_codes = pend_q;

endmodule

// File: rtl/pow2_tick_divider.sv
module pow2_tick_divider
    import pow2_div_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int STRIDE = 4,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] tick_o
);

    logic [NUM_CH*CODE_W-1:0] pend_codes;
    logic [NUM_CH*CODE_W-1:0] act_codes;

    pow2_cfg_regs #(
        .NUM_CH (NUM_CH),
        .STRIDE (STRIDE),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .src_valid  (src_valid),
        .act_codes  (act_codes),
        .pend_codes (pend_codes),
        .rd_data    (rd_data)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pow2_div_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .src_valid (src_valid),
            .pend_code (pend_codes[g*CODE_W +: CODE_W]),
            .act_code  (act_codes[g*CODE_W +: CODE_W]),
            .tick      (tick_o[g])
        );
    end

endmodule

// File: rtl/pow2_tick_divider_chk.sv
module pow2_tick_divider_chk
    import pow2_div_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     src_valid,
    input logic [NUM_CH-1:0]        tick_o,
    input logic [NUM_CH*CODE_W-1:0] act_codes
);

    // R4: a quiet source silences every stream on the next cycle
    p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !src_valid |=> (tick_o == '0));

    // R9: reset leaves all ticks low
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (tick_o == '0));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R2: a stream that runs code 0 stays silent
        p_off_silent_r2: assert property (@(posedge clk) disable iff (rst)
            (act_codes[g*CODE_W +: CODE_W] == '0) |=> !tick_o[g]);

        // R3: code 1 ticks on every valid cycle
        p_div1_every_r3: assert property (@(posedge clk) disable iff (rst)
            (src_valid && (act_codes[g*CODE_W +: CODE_W] == code_t'(1))) |=> tick_o[g]);

        // R3: with a divide of two or more, ticks never come back to back
        p_no_double_r3: assert property (@(posedge clk) disable iff (rst)
            (tick_o[g] && (act_codes[g*CODE_W +: CODE_W] > code_t'(1))) |=> !tick_o[g]);
    end

endmodule

bind pow2_tick_divider pow2_tick_divider_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_valid (src_valid),
    .tick_o    (tick_o),
    .act_codes (act_codes)
);

// File: tb/test_pow2_tick_divider.sv
module test_pow2_tick_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_valid = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [2:0]  tick_o;

    pow2_tick_divider i_pow2_tick_divider (
        .clk       (clk),
        .rst       (rst),
        .src_valid (src_valid),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .tick_o    (tick_o)
    );

    always #10 clk = ~clk;   // 50 MHz

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 0;

    // behavioural model: countdown to the next tick per stream
    int  m_pend [3];
    int  m_act  [3];
    int  m_left [3];
    bit  m_tick [3];
    bit  m_prev_valid = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_pend[c] = 0; m_act[c] = 0; m_left[c] = 0; m_tick[c] = 0;
            end
        end else begin
            for (int c = 0; c < 3; c++) begin
                bit fire;
                fire = (m_act[c] != 0) && (m_left[c] == 1);
                m_tick[c] = src_valid && fire;
                if (!src_valid || m_act[c] == 0 || fire) begin
                    m_act[c]  = m_pend[c];
                    m_left[c] = (m_pend[c] == 0) ? 0 : (1 << (m_pend[c] - 1));
                end else begin
                    m_left[c] = m_left[c] - 1;
                end
            end
            if (wr_en && addr == 2'd0)
                for (int c = 0; c < 3; c++) m_pend[c] = (wr_data >> (4 * c)) & 7;
        end
        m_prev_valid = src_valid;
    end

    function automatic logic [15:0] model_rd();
        logic [15:0] v = '0;
        if (addr == 2'd0) begin
            for (int c = 0; c < 3; c++) v |= 16'(m_pend[c]) << (4 * c);
        end else if (addr == 2'd1) begin
            for (int c = 0; c < 3; c++) v |= 16'(m_act[c]) << (4 * c);
            v[12] = src_valid;
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // compare with the model on every cycle
    always @(negedge clk) begin
        if (cyc > 0 && !done) begin
            for (int c = 0; c < 3; c++) begin
                string tag;
                tag = !m_prev_valid ? "R4" : (m_act[c] == 0 && !m_tick[c]) ? "R2" : "R3";
                check(tick_o[c] == m_tick[c], tag, tick_o[c], m_tick[c]);
            end
            check(rd_data == model_rd(), (addr == 2'd0) ? "R7" : "R8", rd_data, model_rd());
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic write(input logic [1:0] a, input logic [15:0] d);
        step(1);
        wr_en = 1'b1; addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic count_ticks(input int ch, input int n, output int k);
        k = 0;
        repeat (n) begin
            @(negedge clk);
            if (tick_o[ch]) k++;
        end
    endtask

    task automatic wait_tick(input int ch);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!tick_o[ch] && guard < 200);
    endtask

    int k, t0;

    initial begin
        // R9: reset state
        step(3);
        rst = 1'b0;
        @(negedge clk);
        check(tick_o == 3'b000, "R9", tick_o, 0);
        check(rd_data == 16'h0000, "R9", rd_data, 0);

        // R1 / R3: three streams at once, codes 1, 2, 3
        src_valid = 1'b1;
        write(2'd0, 16'h0321);
        step(4);
        fork
            begin count_ticks(0, 64, k); check(k == 64, "R1", k, 64); end
            begin int k1; count_ticks(1, 64, k1); check(k1 == 32, "R1", k1, 32); end
            begin int k2; count_ticks(2, 64, k2); check(k2 == 16, "R3", k2, 16); end
        join

        // R7 / R8: readback of stored and running codes
        step(1);
        addr = 2'd0; @(negedge clk);
        check(rd_data == 16'h0321, "R7", rd_data, 16'h0321);
        step(1);
        addr = 2'd1; @(negedge clk);
        check(rd_data == 16'h1321, "R8", rd_data, 16'h1321);
        step(1);
        addr = 2'd2; @(negedge clk);
        check(rd_data == 16'h0000, "R8", rd_data, 0);

        // R8: writes to other addresses leave the codes alone
        write(2'd1, 16'h0777);
        write(2'd3, 16'h0555);
        @(negedge clk);
        check(rd_data == 16'h0321, "R8", rd_data, 16'h0321);

        // R3: largest divide on stream 0
        write(2'd0, 16'h0327);
        step(3);
        count_ticks(0, 128, k);
        check(k == 2, "R3", k, 2);

        // R2: stream 2 switched off
        write(2'd0, 16'h0027);
        step(20);
        count_ticks(2, 40, k);
        check(k == 0, "R2", k, 0);

        // R6: code change mid-period keeps the old spacing once
        write(2'd0, 16'h0047);
        wait_tick(1);
        wait_tick(1);
        t0 = cyc;
        write(2'd0, 16'h0027);
        wait_tick(1);
        check(cyc - t0 == 8, "R6", cyc - t0, 8);
        t0 = cyc;
        wait_tick(1);
        check(cyc - t0 == 2, "R6", cyc - t0, 2);

        // R4: quiet source silences all streams
        write(2'd0, 16'h0117);
        step(1);
        src_valid = 1'b0;
        step(1);
        count_ticks(0, 10, k); check(k == 0, "R4", k, 0);
        count_ticks(1, 10, k); check(k == 0, "R4", k, 0);

        // R5: restart from zero when the source returns
        step(1);
        src_valid = 1'b1;
        t0 = cyc;
        wait_tick(0);
        check(cyc - t0 == 64, "R5", cyc - t0, 64);

        // R9: reset in mid-run
        step(1);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        @(negedge clk);
        check(tick_o == 3'b000, "R9", tick_o, 0);
        check(rd_data == 16'h0000, "R9", rd_data, 0);

        step(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(20 * 200000);
        done = 1;
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule